// File: doc/BRIEF.md
# Split Completion Tracker and Generator

This block sits inside a bridge. It keeps a record of which split read requests the bridge has issued and not yet seen answered. It also sorts the split completions that arrive on the bus. Two tag slots exist. A request-issue event marks a slot busy. An incoming completion beat whose requester ID equals the bridge's own ID is always claimed, whether or not its tag is live. Its data is forwarded with its tag when that tag is busy, and dropped quietly when it is not. A beat carrying any other requester ID is left alone.

The block also produces the attribute bits and the message index for the completions the bridge sends back when a forwarded read fails. An abort on a busy tag retires that tag and emits one generated completion. A queue-discard event empties every slot at once and emits one generated completion that flags the error. All outputs are registered, so each one reflects the inputs of the previous clock edge. Every event in a cycle is judged against the busy state held before that edge.

Top module: `splt_cpl_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `busy_mask` and every output clear to 0 after that edge.
- R2: `req_valid` with `req_tag` naming a free slot sets that slot's bit in `busy_mask` (bit index = tag) after the edge.
- R3: `req_valid` on a tag that is already busy leaves that slot unchanged and sets `proto_err`; `proto_err` stays 1 until reset.
- R4: A completion beat whose `cpl_rid` differs from `own_id` produces no `cpl_claim`, no `rd_valid` and no `cpl_drop`, and leaves `busy_mask` unchanged.
- R5: A beat with `cpl_rid` equal to `own_id` on a busy tag gives `cpl_claim`=1 and `rd_valid`=1 one cycle later, with `rd_tag` and `rd_data` equal to the beat's tag and data.
- R6: A beat accepted under R5 with `cpl_last`=1 frees its tag; a beat without `cpl_last` leaves the tag busy.
- R7: A beat with `cpl_rid` equal to `own_id` on a tag that is not busy gives `cpl_claim`=1 and `cpl_drop`=1 with `rd_valid`=0 one cycle later.
- R8: `abort_valid` on a busy tag frees that tag and gives one cycle later `gen_valid`=1 and `gen_tag` equal to the abort tag, with `msg_index` 8'h01 when `abort_target`=1 (target-abort) and 8'h00 otherwise (master-abort).
- R9: `attr_bcm` is always 0. `attr_sce` is 1 only for a target-abort with `abort_mem`=1 or for a queue discard. `attr_scm` always equals `attr_sce`. All three are 0 when `gen_valid` is 0.
- R10: `queue_discard` clears all of `busy_mask` after the edge. It takes precedence over a same-cycle abort and gives `gen_valid`=1, `gen_tag`=0, `attr_sce`=1 and `msg_index`=8'h00.
- R11: `abort_valid` on a tag that is not busy is ignored: `gen_valid` stays 0 and `busy_mask` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_id | input | ID_W | The bridge's own requester ID |
| req_valid | input | 1 | A split request is being issued |
| req_tag | input | TAG_W | Tag of the issued request |
| cpl_valid | input | 1 | An incoming completion beat is present |
| cpl_last | input | 1 | The beat is the final beat of its completion |
| cpl_rid | input | ID_W | Requester ID carried by the beat |
| cpl_tag | input | TAG_W | Tag carried by the beat |
| cpl_data | input | DATA_W | Data of the beat |
| abort_valid | input | 1 | A forwarded read was aborted |
| abort_tag | input | TAG_W | Tag of the aborted read |
| abort_target | input | 1 | 1 = target-abort, 0 = master-abort |
| abort_mem | input | 1 | The aborted read was a memory read |
| queue_discard | input | 1 | The upstream queues are being discarded |
| busy_mask | output | NUM_TAGS | Outstanding slots, one bit per tag |
| proto_err | output | 1 | Sticky flag for a request on a busy tag |
| cpl_claim | output | 1 | The beat was claimed (device select) |
| rd_valid | output | 1 | Accepted completion data is present |
| rd_tag | output | TAG_W | Tag of the accepted data |
| rd_data | output | DATA_W | Accepted data |
| cpl_drop | output | 1 | A claimed beat was discarded |
| gen_valid | output | 1 | A generated error completion is present |
| gen_tag | output | TAG_W | Tag of the generated completion |
| attr_bcm | output | 1 | Byte-count-modified attribute |
| attr_sce | output | 1 | Split-completion-error attribute |
| attr_scm | output | 1 | Split-completion-message attribute |
| msg_index | output | 8 | Error message index |

## Verification
The hardest case to reach from the ports is a set of events landing in one cycle. Examples are a final completion beat and an abort on the same tag, a new request on a tag that is being freed in that same cycle, and a queue discard arriving together with any of these. Each of these cases depends on every event reading the busy state from before the edge. The stimulus has only two tags and sends a matching requester ID about half the time. It raises requests, beats and aborts independently at high rates and adds occasional discards. This makes such collisions frequent, and a behavioural model checks the result every cycle.

// File: rtl/splt_pkg.sv
package splt_pkg;

  typedef enum logic [7:0] {
    MSG_MASTER_ABORT = 8'h00,
    MSG_TARGET_ABORT = 8'h01
  } msg_idx_e;

  typedef struct packed {
    logic bcm;
    logic sce;
    logic scm;
  } cpl_attr_t;

endpackage

// File: rtl/splt_tag_table.sv
module splt_tag_table #(
  parameter int NUM_TAGS = 2,
  parameter int TAG_W    = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_v,
  input  logic [TAG_W-1:0]    set_tag,
  input  logic [NUM_TAGS-1:0] free_mask,
  input  logic                clear_all,
  output logic [NUM_TAGS-1:0] busy,
  output logic                proto_err
);

  logic set_hits_busy;

  assign set_hits_busy = set_v && busy[set_tag];

  // one state bit per slot; set and free are exclusive since set needs idle, free needs busy
  for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
    logic slot_q;
    always_ff @(posedge clk) begin
      if (rst || clear_all) begin
        slot_q <= 1'b0;
      end else if (set_v && (set_tag == TAG_W'(t)) && !slot_q) begin
        slot_q <= 1'b1;
      end else if (free_mask[t]) begin
        slot_q <= 1'b0;
      end
    end
    assign busy[t] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      proto_err <= 1'b0;
    end else if (set_hits_busy) begin
      proto_err <= 1'b1;
    end
  end

endmodule

// File: rtl/splt_cpl_rx.sv
module splt_cpl_rx #(
  parameter int ID_W     = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_TAGS = 2,
  parameter int TAG_W    = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ID_W-1:0]     own_id,
  input  logic                cpl_valid,
  input  logic                cpl_last,
  input  logic [ID_W-1:0]     cpl_rid,
  input  logic [TAG_W-1:0]    cpl_tag,
  input  logic [DATA_W-1:0]   cpl_data,
  input  logic [NUM_TAGS-1:0] busy,
  output logic [NUM_TAGS-1:0] free_mask,
  output logic                claim_q,
  output logic                rd_valid_q,
  output logic [TAG_W-1:0]    rd_tag_q,
  output logic [DATA_W-1:0]   rd_data_q,
  output logic                drop_q
);

  logic id_hit;
  logic tag_live;
  logic accept;

  assign id_hit   = cpl_valid && (cpl_rid == own_id);
  assign tag_live = busy[cpl_tag];
  assign accept   = id_hit && tag_live;

  always_comb begin
    free_mask = '0;
    if (accept && cpl_last) begin
      free_mask[cpl_tag] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_q    <= 1'b0;
      rd_valid_q <= 1'b0;
      drop_q     <= 1'b0;
      rd_tag_q   <= '0;
      rd_data_q  <= '0;
    end else begin
      claim_q    <= id_hit;
      rd_valid_q <= accept;
      drop_q     <= id_hit && !tag_live;
      if (accept) begin
        rd_tag_q  <= cpl_tag;
        rd_data_q <= cpl_data;
      end
    end
  end

endmodule

// File: rtl/splt_err_gen.sv
module splt_err_gen
  import splt_pkg::*;
#(
  parameter int NUM_TAGS = 2,
  parameter int TAG_W    = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                abort_valid,
  input  logic [TAG_W-1:0]    abort_tag,
  input  logic                abort_target,
  input  logic                abort_mem,
  input  logic                queue_discard,
  input  logic [NUM_TAGS-1:0] busy,
  output logic [NUM_TAGS-1:0] free_mask,
  output logic                gen_valid_q,
  output logic [TAG_W-1:0]    gen_tag_q,
  output cpl_attr_t           attr_q,
  output msg_idx_e            msg_q
);

  logic abort_live;
  logic sce_abort;

  assign abort_live = abort_valid && busy[abort_tag];
  assign sce_abort  = abort_target && abort_mem;

  always_comb begin
    free_mask = '0;
    if (abort_live) begin
      free_mask[abort_tag] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_valid_q <= 1'b0;
      gen_tag_q   <= '0;
      attr_q      <= '0;
      msg_q       <= MSG_MASTER_ABORT;
    end else if (queue_discard) begin
      gen_valid_q <= 1'b1;
      gen_tag_q   <= '0;
      attr_q      <= '{bcm: 1'b0, sce: 1'b1, scm: 1'b1};
      msg_q       <= MSG_MASTER_ABORT;
    end else if (abort_live) begin
      gen_valid_q <= 1'b1;
      gen_tag_q   <= abort_tag;
      attr_q      <= '{bcm: 1'b0, sce: sce_abort, scm: sce_abort};
      msg_q       <= abort_target ? MSG_TARGET_ABORT : MSG_MASTER_ABORT;
    end else begin
      gen_valid_q <= 1'b0;
      gen_tag_q   <= '0;
      attr_q      <= '0;
      msg_q       <= MSG_MASTER_ABORT;
    end
  end

endmodule

// File: rtl/splt_cpl_engine.sv
module splt_cpl_engine
  import splt_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_TAGS = 2,
  localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ID_W-1:0]     own_id,
  input  logic                req_valid,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic                cpl_valid,
  input  logic                cpl_last,
  input  logic [ID_W-1:0]     cpl_rid,
  input  logic [TAG_W-1:0]    cpl_tag,
  input  logic [DATA_W-1:0]   cpl_data,
  input  logic                abort_valid,
  input  logic [TAG_W-1:0]    abort_tag,
  input  logic                abort_target,
  input  logic                abort_mem,
  input  logic                queue_discard,
  output logic [NUM_TAGS-1:0] busy_mask,
  output logic                proto_err,
  output logic                cpl_claim,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [DATA_W-1:0]   rd_data,
  output logic                cpl_drop,
  output logic                gen_valid,
  output logic [TAG_W-1:0]    gen_tag,
  output logic                attr_bcm,
  output logic                attr_sce,
  output logic                attr_scm,
  output logic [7:0]          msg_index
);

  logic [NUM_TAGS-1:0] rx_free;
  logic [NUM_TAGS-1:0] err_free;
  cpl_attr_t           attr;
  msg_idx_e            msg;

  splt_tag_table #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) tags_i (
    .clk       (clk),
    .rst       (rst),
    .set_v     (req_valid),
    .set_tag   (req_tag),
    .free_mask (rx_free | err_free),
    .clear_all (queue_discard),
    .busy      (busy_mask),
    .proto_err (proto_err)
  );

  splt_cpl_rx #(.ID_W(ID_W), .DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) rx_i (
    .clk        (clk),
    .rst        (rst),
    .own_id     (own_id),
    .cpl_valid  (cpl_valid),
    .cpl_last   (cpl_last),
    .cpl_rid    (cpl_rid),
    .cpl_tag    (cpl_tag),
    .cpl_data   (cpl_data),
    .busy       (busy_mask),
    .free_mask  (rx_free),
    .claim_q    (cpl_claim),
    .rd_valid_q (rd_valid),
    .rd_tag_q   (rd_tag),
    .rd_data_q  (rd_data),
    .drop_q     (cpl_drop)
  );

  splt_err_gen #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) err_i (
    .clk           (clk),
    .rst           (rst),
    .abort_valid   (abort_valid),
    .abort_tag     (abort_tag),
    .abort_target  (abort_target),
    .abort_mem     (abort_mem),
    .queue_discard (queue_discard),
    .busy          (busy_mask),
    .free_mask     (err_free),
    .gen_valid_q   (gen_valid),
    .gen_tag_q     (gen_tag),
    .attr_q        (attr),
    .msg_q         (msg)
  );

  assign attr_bcm  = attr.bcm;
  assign attr_sce  = attr.sce;
  assign attr_scm  = attr.scm;
  assign msg_index = msg;

endmodule

// File: rtl/splt_cpl_engine_chk.sv
module splt_cpl_engine_chk #(
  parameter int ID_W     = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_TAGS = 2,
  localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic [ID_W-1:0]     own_id,
  input logic                req_valid,
  input logic [TAG_W-1:0]    req_tag,
  input logic                cpl_valid,
  input logic [ID_W-1:0]     cpl_rid,
  input logic [TAG_W-1:0]    cpl_tag,
  input logic                abort_valid,
  input logic [TAG_W-1:0]    abort_tag,
  input logic                queue_discard,
  input logic [NUM_TAGS-1:0] busy_mask,
  input logic                proto_err,
  input logic                cpl_claim,
  input logic                rd_valid,
  input logic                cpl_drop,
  input logic                gen_valid,
  input logic                attr_bcm,
  input logic                attr_sce,
  input logic                attr_scm
);

  assert_refused_req_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && busy_mask[req_tag] |=> proto_err);

  assert_perr_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  assert_foreign_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && (cpl_rid != own_id) |=> !cpl_claim && !rd_valid && !cpl_drop);

  assert_claim_own_R5: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && (cpl_rid == own_id) |=> cpl_claim);

  assert_stray_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && (cpl_rid == own_id) && !busy_mask[cpl_tag] |=> cpl_drop && !rd_valid);

  assert_attr_shape_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> !attr_bcm && (attr_scm == attr_sce) && (gen_valid || !attr_sce));

  assert_discard_clears_R10: assert property (@(posedge clk) disable iff (rst)
    queue_discard |=> (busy_mask == '0) && gen_valid && attr_sce);

  assert_idle_abort_R11: assert property (@(posedge clk) disable iff (rst)
    abort_valid && !busy_mask[abort_tag] && !queue_discard |=> !gen_valid);

endmodule

bind splt_cpl_engine splt_cpl_engine_chk #(
  .ID_W(ID_W), .DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS)
) chk_i (.*);

// File: tb/splt_cpl_engine_tb_top.sv
`timescale 1ns/1ps
module splt_cpl_engine_tb_top;

  localparam int ID_W = 16;
  localparam int DW   = 32;
  localparam logic [ID_W-1:0] OWN = 16'hA5C3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst = 1'b1;
  logic [ID_W-1:0] own_id = OWN;
  logic            req_valid = 0, req_tag = 0;
  logic            cpl_valid = 0, cpl_last = 0, cpl_tag = 0;
  logic [ID_W-1:0] cpl_rid = '0;
  logic [DW-1:0]   cpl_data = '0;
  logic            abort_valid = 0, abort_tag = 0, abort_target = 0, abort_mem = 0;
  logic            queue_discard = 0;

  logic [1:0]    busy_mask;
  logic          proto_err, cpl_claim, rd_valid, cpl_drop, gen_valid;
  logic          rd_tag, gen_tag, attr_bcm, attr_sce, attr_scm;
  logic [DW-1:0] rd_data;
  logic [7:0]    msg_index;

  splt_cpl_engine #(.ID_W(ID_W), .DATA_W(DW), .NUM_TAGS(2)) dut_i (.*);

  int checks = 0;
  int errors = 0;

  // reference model state and expected outputs
  logic [1:0]  m_busy = '0;
  logic        m_perr = 0;
  logic        e_claim = 0, e_rdv = 0, e_rdt = 0, e_drop = 0, e_gv = 0, e_gt = 0, e_sce = 0;
  logic [DW-1:0] e_rdd = '0;
  logic [7:0]  e_msg = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compute expectation from current inputs, step one clock, compare at negedge
  task automatic cycle();
    logic [1:0] nb;
    logic own, live_c, live_a;
    if (rst) begin
      m_busy = '0; m_perr = 0;
      e_claim = 0; e_rdv = 0; e_rdt = 0; e_rdd = '0; e_drop = 0;
      e_gv = 0; e_gt = 0; e_sce = 0; e_msg = 0;
    end else begin
      nb     = m_busy;
      own    = cpl_valid && (cpl_rid == OWN);
      live_c = m_busy[cpl_tag];
      live_a = abort_valid && m_busy[abort_tag];
      e_claim = own;
      e_rdv   = own && live_c;
      e_drop  = own && !live_c;
      if (own && live_c) begin
        e_rdt = cpl_tag; e_rdd = cpl_data;
        if (cpl_last) nb[cpl_tag] = 1'b0;
      end
      if (live_a) nb[abort_tag] = 1'b0;
      if (queue_discard) begin
        e_gv = 1; e_gt = 0; e_sce = 1; e_msg = 8'h00;
      end else if (live_a) begin
        e_gv = 1; e_gt = abort_tag; e_sce = abort_target && abort_mem;
        e_msg = abort_target ? 8'h01 : 8'h00;
      end else begin
        e_gv = 0; e_gt = 0; e_sce = 0; e_msg = 0;
      end
      if (req_valid) begin
        if (m_busy[req_tag]) m_perr = 1;
        else nb[req_tag] = 1'b1;
      end
      if (queue_discard) nb = '0;
      m_busy = nb;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2 busy_mask", busy_mask, m_busy);
    chk("R3 proto_err", proto_err, m_perr);
    chk("R5 cpl_claim", cpl_claim, e_claim);
    chk("R5 rd_valid", rd_valid, e_rdv);
    if (e_rdv) begin
      chk("R5 rd_tag", rd_tag, e_rdt);
      chk("R5 rd_data", rd_data, e_rdd);
    end
    chk("R7 cpl_drop", cpl_drop, e_drop);
    chk("R8 gen_valid", gen_valid, e_gv);
    if (e_gv) chk("R8 gen_tag", gen_tag, e_gt);
    chk("R8 msg_index", msg_index, e_msg);
    chk("R9 attr_sce", attr_sce, e_sce);
    chk("R9 attr_scm", attr_scm, e_sce);
    chk("R9 attr_bcm", attr_bcm, 1'b0);
  endtask

  task automatic idle();
    req_valid = 0; cpl_valid = 0; cpl_last = 0; abort_valid = 0; queue_discard = 0;
  endtask

  task automatic send_beat(input logic [ID_W-1:0] rid, input logic tag, input logic last,
                           input logic [DW-1:0] d);
    idle(); cpl_valid = 1; cpl_rid = rid; cpl_tag = tag; cpl_last = last; cpl_data = d;
    cycle();
  endtask

  task automatic issue(input logic tag);
    idle(); req_valid = 1; req_tag = tag; cycle();
  endtask

  task automatic abort_ev(input logic tag, input logic tgt, input logic mem);
    idle(); abort_valid = 1; abort_tag = tag; abort_target = tgt; abort_mem = mem; cycle();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; idle();
    repeat (3) cycle();
    chk("R1 busy after reset", busy_mask, 2'b00);
    chk("R1 outputs after reset",
        {proto_err, cpl_claim, rd_valid, cpl_drop, gen_valid, attr_sce, msg_index}, '0);
    rst = 0;
    idle(); cycle();

    issue(1'b0);
    chk("R2 tag0 busy", busy_mask, 2'b01);

    send_beat(OWN ^ 16'h0010, 1'b0, 1'b1, 32'hDEAD0001);
    chk("R4 foreign not claimed", {cpl_claim, rd_valid, cpl_drop}, 3'b000);
    chk("R4 foreign keeps busy", busy_mask, 2'b01);

    send_beat(OWN, 1'b0, 1'b0, 32'h1111_2222);
    chk("R5 data beat", {rd_valid, rd_tag, rd_data}, {1'b1, 1'b0, 32'h1111_2222});
    chk("R6 non-final keeps busy", busy_mask, 2'b01);
    send_beat(OWN, 1'b0, 1'b1, 32'h3333_4444);
    chk("R6 final frees tag", busy_mask, 2'b00);

    send_beat(OWN, 1'b1, 1'b1, 32'h5555_6666);
    chk("R7 stray claimed and dropped", {cpl_claim, cpl_drop, rd_valid}, 3'b110);

    issue(1'b1);
    issue(1'b1);
    chk("R3 second issue refused", {proto_err, busy_mask}, 3'b110);
    idle(); cycle();
    chk("R3 flag sticky", proto_err, 1'b1);

    abort_ev(1'b0, 1'b1, 1'b1);
    chk("R11 idle abort ignored", {gen_valid, busy_mask}, 3'b010);

    abort_ev(1'b1, 1'b0, 1'b1);
    chk("R8 master abort", {gen_valid, gen_tag, msg_index, attr_sce}, {2'b11, 8'h00, 1'b0});
    issue(1'b1);
    abort_ev(1'b1, 1'b1, 1'b1);
    chk("R8 target abort", {gen_valid, gen_tag, msg_index}, {2'b11, 8'h01});
    chk("R9 target mem sets sce", {attr_sce, attr_scm, attr_bcm}, 3'b110);
    issue(1'b0);
    abort_ev(1'b0, 1'b1, 1'b0);
    chk("R9 target non-mem no sce", {gen_valid, attr_sce}, 2'b10);

    issue(1'b0); issue(1'b1);
    idle(); queue_discard = 1; abort_valid = 1; abort_tag = 1; abort_target = 1; abort_mem = 0;
    cycle();
    chk("R10 discard clears", busy_mask, 2'b00);
    chk("R10 discard completion", {gen_valid, gen_tag, attr_sce, msg_index}, {3'b101, 8'h00});

    for (int i = 0; i < 4000; i++) begin
      req_valid     = ($urandom % 3) == 0;
      req_tag       = 1'($urandom);
      cpl_valid     = ($urandom % 2) == 0;
      cpl_rid       = ($urandom % 2) ? OWN : (OWN ^ 16'($urandom % 7 + 1));
      cpl_tag       = 1'($urandom);
      cpl_last      = ($urandom % 3) == 0;
      cpl_data      = $urandom;
      abort_valid   = ($urandom % 5) == 0;
      abort_tag     = 1'($urandom);
      abort_target  = 1'($urandom);
      abort_mem     = 1'($urandom);
      queue_discard = ($urandom % 40) == 0;
      cycle();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule